// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block lets a small DSP-style core repeat a stretch of code without spending any instructions on loop bookkeeping. It holds four pieces of loop context. The first is the loop start, which is the address of the first instruction in the body. The second is the loop-end address, which marks the last instruction. The third is the remaining iteration count. The fourth is a loop-active flag, and a nested flag sits beside it. A two-entry context stack holds the loop context of enclosing loops.

The sequencer watches the fetch PC every cycle. When the PC equals the loop-end address and the loop is active, the block acts in the same cycle. If iterations remain, it redirects fetch to the loop start. Otherwise it ends the loop and resumes the enclosing one if the stack holds it.

Interrupt save and restore code can push and pop the context directly. A push makes the loop flag active. For that reason the loop-end address resets to all ones, which is an address that is never fetched, so a flag set by a push cannot produce a stray match. Software can also write the loop-end address directly.

Control is a two-state machine. `ST_IDLE` means no loop is active and `ST_LOOP` means a loop is active. Every cycle exactly one operation is selected, in priority order:
- `OP_POP`: restore the context from the stack.
- `OP_PUSH`: save the context onto the stack.
- `OP_DO`: start a new loop.
- `OP_LAWR`: write the loop-end address.
- `OP_REPEAT`: at end of loop, branch back to the loop start.
- `OP_EXIT`: at end of loop, finish the loop.
- `OP_NONE`: nothing to do.

The transitions are:
- `ST_IDLE -> ST_LOOP` on `OP_DO` or `OP_PUSH`.
- `ST_LOOP -> ST_IDLE` on `OP_EXIT` with an empty stack.
- Either state on `OP_POP` or `OP_EXIT` with a non-empty stack: the next state follows the flag held in the popped entry.
- `ST_LOOP -> ST_LOOP` on `OP_REPEAT`, `OP_DO` or `OP_PUSH`.
- Any other operation holds the state.

Top module: `zol_seq`

## Requirements
- R1: While reset is asserted, the loop-end address reads all ones. The loop flag, nested flag, overflow flag and underflow flag read 0, and the count reads 0.
- R2: An end-of-loop event is recognised only when the loop flag is 1 and `pc_i` equals the loop-end address. `redir_o` is never 1 at any other time.
- R3: A push saves the current loop start, loop-end address, count and loop flag onto the stack and sets the loop flag. A push onto a non-empty stack also sets the nested flag, so two successive pushes from reset set both flags.
- R4: A pop on a non-empty stack restores the loop start, loop-end address, count and loop flag from the newest entry. The nested flag clears when the stack becomes empty.
- R5: A DO command loads the loop start with `pc_i + 1`, the loop-end address with `do_end_i` and the count with `do_cnt_i`, and sets the loop flag. If the loop flag was already 1, the outer context is pushed first.
- R6: On an end-of-loop event with a count greater than 1, `redir_o` is 1 in that same cycle and `redir_pc_o` holds the loop start. The count decrements by one at the next clock edge.
- R7: On an end-of-loop event with a count of 1 or 0, there is no redirect. If the stack is non-empty, the outer context is restored; otherwise the loop flag clears.
- R8: When no higher-priority command is present, `la_wr_i` writes `la_wdata_i` into the loop-end address.
- R9: A push onto a full stack is dropped and sets a sticky overflow flag that only reset clears.
- R10: A pop on an empty stack leaves the context unchanged and sets a sticky underflow flag that only reset clears.
- R11: When commands coincide in one cycle, priority is pop, then push, then DO, then the loop-end write, then the end-of-loop event. A lower-priority item is ignored entirely in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | AW | Fetch program counter |
| do_vld_i | input | 1 | DO command strobe |
| do_end_i | input | AW | Loop-end address for DO |
| do_cnt_i | input | CW | Iteration count for DO |
| la_wr_i | input | 1 | Software write of loop-end address |
| la_wdata_i | input | AW | Data for loop-end write |
| hws_push_i | input | 1 | Context push from interrupt save |
| hws_pop_i | input | 1 | Context pop from interrupt restore |
| redir_o | output | 1 | Redirect fetch this cycle |
| redir_pc_o | output | AW | Redirect target (loop start) |
| loop_flag_o | output | 1 | Loop-active flag |
| nest_flag_o | output | 1 | Nested-loop flag |
| la_o | output | AW | Current loop-end address |
| cnt_o | output | CW | Current iteration count |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The bench first sets the loop flag with two pushes straight out of reset and then fetches ordinary addresses. A loop-end address that did not reset to all ones could match one of those fetches and redirect at random. It then runs an inner loop nested in an outer one. A sequencer that failed to restore the outer loop-end address and count on the inner exit would either stop looping early or branch back to the wrong start. Pushes past the stack depth and pops of an empty stack are driven to show that the error flags latch while the stored context survives. Coinciding commands on an end-of-loop cycle are driven to catch a design that redirects while saving or that lets the loop-end write override a DO.

// File: rtl/zol_pkg.sv
package zol_pkg;

    // Loop-active state, mirrored on the loop flag output
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOOP = 1'b1
    } zol_state_e;

    // One operation per cycle, chosen by fixed priority
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_POP    = 3'd1,
        OP_PUSH   = 3'd2,
        OP_DO     = 3'd3,
        OP_LAWR   = 3'd4,
        OP_REPEAT = 3'd5,
        OP_EXIT   = 3'd6
    } zol_op_e;

endpackage

// File: rtl/zol_eol_det.sv
module zol_eol_det #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] lend_i,
    input  logic          active_i,
    output logic          hit_o
);

    // End of loop: fetch reached the last body address while a loop runs
    always_comb begin
        hit_o = active_i && (pc_i == lend_i);
    end

endmodule

// File: rtl/zol_ctx_stack.sv
module zol_ctx_stack #(
    parameter int W     = 49,
    parameter int DEPTH = 2,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         last_o,
    output logic         ovf_o,
    output logic         unf_o
);

    logic [PW-1:0] ptr_q;
    logic          full;
    logic          do_push;
    logic          do_pop;
    logic [W-1:0]  ent [DEPTH];

    assign full    = (ptr_q == PW'(DEPTH));
    assign empty_o = (ptr_q == '0);
    assign last_o  = (ptr_q == PW'(1));
    assign do_push = push_i && !pop_i && !full;
    assign do_pop  = pop_i && !empty_o;

    // One register per entry; the write lands at the current fill level
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (do_push && (ptr_q == PW'(g))) begin
                ent_q <= din_i;
            end
        end
        assign ent[g] = ent_q;
    end

    // Newest entry sits just below the fill pointer
    always_comb begin
        dout_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr_q == PW'(i + 1)) begin
                dout_o = ent[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (do_push) begin
                ptr_q <= ptr_q + PW'(1);
            end else if (do_pop) begin
                ptr_q <= ptr_q - PW'(1);
            end
            if (push_i && !pop_i && full) begin
                ovf_o <= 1'b1;
            end
            if (pop_i && empty_o) begin
                unf_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pop_req_i,
    input  logic    push_req_i,
    input  logic    do_req_i,
    input  logic    la_wr_i,
    input  logic    hit_i,
    input  logic    cnt_gt1_i,
    input  logic    stk_empty_i,
    input  logic    top_flag_i,
    output zol_op_e op_o,
    output logic    loop_flag_o
);

    zol_state_e state_q;
    zol_state_e state_d;
    zol_state_e resume_st;

    // Fixed-priority operation select
    always_comb begin
        if (pop_req_i) begin
            op_o = OP_POP;
        end else if (push_req_i) begin
            op_o = OP_PUSH;
        end else if (do_req_i) begin
            op_o = OP_DO;
        end else if (la_wr_i) begin
            op_o = OP_LAWR;
        end else if (hit_i && cnt_gt1_i) begin
            op_o = OP_REPEAT;
        end else if (hit_i) begin
            op_o = OP_EXIT;
        end else begin
            op_o = OP_NONE;
        end
    end

    // State after a pop follows the flag stored in the popped entry
    assign resume_st = top_flag_i ? ST_LOOP : ST_IDLE;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (op_o)
            OP_POP:    state_d = stk_empty_i ? state_q : resume_st;
            OP_PUSH:   state_d = ST_LOOP;
            OP_DO:     state_d = ST_LOOP;
            OP_EXIT:   state_d = stk_empty_i ? ST_IDLE : resume_st;
            OP_REPEAT: state_d = ST_LOOP;
            OP_LAWR:   state_d = state_q;
            OP_NONE:   state_d = state_q;
            default:   state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        loop_flag_o = (state_q == ST_LOOP);
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc_i,
    input  logic          do_vld_i,
    input  logic [AW-1:0] do_end_i,
    input  logic [CW-1:0] do_cnt_i,
    input  logic          la_wr_i,
    input  logic [AW-1:0] la_wdata_i,
    input  logic          hws_push_i,
    input  logic          hws_pop_i,
    output logic          redir_o,
    output logic [AW-1:0] redir_pc_o,
    output logic          loop_flag_o,
    output logic          nest_flag_o,
    output logic [AW-1:0] la_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int CTX_W = 1 + 2 * AW + CW;

    logic [AW-1:0]    start_q;
    logic [AW-1:0]    lend_q;
    logic [CW-1:0]    cnt_q;
    logic             nest_q;
    logic             lf;
    logic             hit;
    logic             cnt_gt1;
    zol_op_e          op;

    logic             stk_push;
    logic             stk_pop;
    logic             stk_empty;
    logic             stk_last;
    logic [CTX_W-1:0] ctx_cur;
    logic [CTX_W-1:0] ctx_top;
    logic             top_flag;
    logic [AW-1:0]    top_start;
    logic [AW-1:0]    top_lend;
    logic [CW-1:0]    top_cnt;
    logic             restore;

    assign cnt_gt1 = (cnt_q > CW'(1));
    assign ctx_cur = {lf, start_q, lend_q, cnt_q};
    assign {top_flag, top_start, top_lend, top_cnt} = ctx_top;

    zol_eol_det #(.AW(AW)) eol_i (
        .pc_i     (pc_i),
        .lend_i   (lend_q),
        .active_i (lf),
        .hit_o    (hit)
    );

    zol_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_req_i   (hws_pop_i),
        .push_req_i  (hws_push_i),
        .do_req_i    (do_vld_i),
        .la_wr_i     (la_wr_i),
        .hit_i       (hit),
        .cnt_gt1_i   (cnt_gt1),
        .stk_empty_i (stk_empty),
        .top_flag_i  (top_flag),
        .op_o        (op),
        .loop_flag_o (lf)
    );

    // Stack traffic: explicit push, DO inside a running loop, pop, exit to outer
    assign stk_push = (op == OP_PUSH) || ((op == OP_DO) && lf);
    assign stk_pop  = (op == OP_POP) || ((op == OP_EXIT) && !stk_empty);
    assign restore  = stk_pop && !stk_empty;

    zol_ctx_stack #(.W(CTX_W), .DEPTH(DEPTH)) stk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .din_i   (ctx_cur),
        .dout_o  (ctx_top),
        .empty_o (stk_empty),
        .last_o  (stk_last),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    // Context registers; loop-end resets to an address that is never fetched
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            lend_q  <= '1;
            cnt_q   <= '0;
            nest_q  <= 1'b0;
        end else begin
            if (restore) begin
                start_q <= top_start;
                lend_q  <= top_lend;
                cnt_q   <= top_cnt;
                if (stk_last) begin
                    nest_q <= 1'b0;
                end
            end else begin
                unique case (op)
                    OP_PUSH: begin
                        if (!stk_empty) begin
                            nest_q <= 1'b1;
                        end
                    end
                    OP_DO: begin
                        start_q <= pc_i + AW'(1);
                        lend_q  <= do_end_i;
                        cnt_q   <= do_cnt_i;
                        if (lf && !stk_empty) begin
                            nest_q <= 1'b1;
                        end
                    end
                    OP_LAWR:   lend_q <= la_wdata_i;
                    OP_REPEAT: cnt_q  <= cnt_q - CW'(1);
                    OP_POP, OP_EXIT, OP_NONE: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign redir_o     = (op == OP_REPEAT);
    assign redir_pc_o  = start_q;
    assign loop_flag_o = lf;
    assign nest_flag_o = nest_q;
    assign la_o        = lend_q;
    assign cnt_o       = cnt_q;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pc_i,
    input logic          do_vld_i,
    input logic [AW-1:0] do_end_i,
    input logic [CW-1:0] do_cnt_i,
    input logic          hws_push_i,
    input logic          hws_pop_i,
    input logic          redir_o,
    input logic          loop_flag_o,
    input logic [AW-1:0] la_o,
    input logic [CW-1:0] cnt_o,
    input logic          ovf_o,
    input logic          unf_o
);

    AST_RESET_SAFE: assert property (@(posedge clk) !rst_n |=> (la_o == '1) && !loop_flag_o); // R1

    AST_NO_STRAY_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (loop_flag_o && (pc_i == la_o))); // R2

    AST_PUSH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hws_push_i && !hws_pop_i) |=> loop_flag_o); // R3

    AST_DO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_vld_i && !hws_push_i && !hws_pop_i) |=>
        (loop_flag_o && (la_o == $past(do_end_i)) && (cnt_o == $past(do_cnt_i)))); // R5

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |=> (cnt_o == CW'($past(cnt_o) - CW'(1)))); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R9

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o); // R10

endmodule

bind zol_seq zol_seq_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_i        (pc_i),
    .do_vld_i    (do_vld_i),
    .do_end_i    (do_end_i),
    .do_cnt_i    (do_cnt_i),
    .hws_push_i  (hws_push_i),
    .hws_pop_i   (hws_pop_i),
    .redir_o     (redir_o),
    .loop_flag_o (loop_flag_o),
    .la_o        (la_o),
    .cnt_o       (cnt_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/zol_seq_tb_top.sv
module zol_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pc;
    logic        do_vld;
    logic [15:0] do_end;
    logic [15:0] do_cnt;
    logic        la_wr;
    logic [15:0] la_wdata;
    logic        push;
    logic        pop;
    logic        redir;
    logic [15:0] redir_pc;
    logic        lf;
    logic        nl;
    logic [15:0] la;
    logic [15:0] cnt;
    logic        ovf;
    logic        unf;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    zol_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_i        (pc),
        .do_vld_i    (do_vld),
        .do_end_i    (do_end),
        .do_cnt_i    (do_cnt),
        .la_wr_i     (la_wr),
        .la_wdata_i  (la_wdata),
        .hws_push_i  (push),
        .hws_pop_i   (pop),
        .redir_o     (redir),
        .redir_pc_o  (redir_pc),
        .loop_flag_o (lf),
        .nest_flag_o (nl),
        .la_o        (la),
        .cnt_o       (cnt),
        .ovf_o       (ovf),
        .unf_o       (unf)
    );

    typedef struct packed {
        logic        dv;
        logic [15:0] pc;
        logic [15:0] lend;
        logic [15:0] cnt;
        logic        er;
        logic [15:0] epc;
        logic        elf;
        logic [15:0] ecnt;
    } vec_t;

    // Single loop of three iterations over 0x11..0x14
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0010, 16'h0014, 16'd3, 1'b0, 16'h0000, 1'b1, 16'd3},
        '{1'b0, 16'h0011, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b1, 16'd3},
        '{1'b0, 16'h0014, 16'h0000, 16'd0, 1'b1, 16'h0011, 1'b1, 16'd2},
        '{1'b0, 16'h0011, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b1, 16'd2},
        '{1'b0, 16'h0014, 16'h0000, 16'd0, 1'b1, 16'h0011, 1'b1, 16'd1},
        '{1'b0, 16'h0014, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b0, 16'd1},
        '{1'b0, 16'h0014, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b0, 16'd1},
        '{1'b0, 16'hFFFF, 16'h0000, 16'd0, 1'b0, 16'h0000, 1'b0, 16'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        do_vld = 1'b0; la_wr = 1'b0; push = 1'b0; pop = 1'b0;
        do_end = '0; do_cnt = '0; la_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clr();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clr();
        pc = 16'h0000;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 la", la, 16'hFFFF);
        chk("R1 lf", lf, 0);
        chk("R1 nl", nl, 0);
        chk("R1 ovf/unf", {ovf, unf}, 0);
        chk("R1 cnt", cnt, 0);
        rst_n = 1'b1;
    endtask

    task automatic do_cmd(input logic [15:0] p, input logic [15:0] e, input logic [15:0] c);
        pc = p; do_vld = 1'b1; do_end = e; do_cnt = c;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        do_reset();

        // Table-driven single loop: R5, R6, R7, R2
        for (int i = 0; i < NV; i++) begin
            pc = VEC[i].pc; do_vld = VEC[i].dv; do_end = VEC[i].lend; do_cnt = VEC[i].cnt;
            #1;
            chk($sformatf("R6 redir row %0d", i), redir, VEC[i].er);
            if (VEC[i].er) chk($sformatf("R6 target row %0d", i), redir_pc, VEC[i].epc);
            tick();
            chk($sformatf("R7 flag row %0d", i), lf, VEC[i].elf);
            chk($sformatf("R5 count row %0d", i), cnt, VEC[i].ecnt);
        end

        // Interrupt pushes with a safe loop-end: R1 R2 R3 R9 R4 R10
        do_reset();
        pc = 16'hFFFF; #1;
        chk("R2 idle no redir", redir, 0);
        push = 1'b1; tick();
        chk("R3 first push flag", lf, 1);
        chk("R3 first push nest", nl, 0);
        pc = 16'h0020; #1;
        chk("R1 no stray match", redir, 0);
        push = 1'b1; tick();
        chk("R3 second push nest", nl, 1);
        chk("R9 no ovf yet", ovf, 0);
        push = 1'b1; tick();
        chk("R9 ovf set", ovf, 1);
        pop = 1'b1; tick();
        chk("R4 pop flag", lf, 1);
        chk("R4 pop nest held", nl, 1);
        chk("R4 pop la", la, 16'hFFFF);
        pop = 1'b1; tick();
        chk("R4 last pop flag", lf, 0);
        chk("R4 last pop nest", nl, 0);
        pop = 1'b1; tick();
        chk("R10 unf set", unf, 1);
        chk("R10 la kept", la, 16'hFFFF);
        chk("R10 flag kept", lf, 0);
        tick();
        chk("R9 ovf sticky", ovf, 1);
        chk("R10 unf sticky", unf, 1);

        // Software write and nested loops: R8 R5 R6 R7
        do_reset();
        la_wr = 1'b1; la_wdata = 16'h0050; tick();
        chk("R8 la write", la, 16'h0050);
        do_cmd(16'h0020, 16'h0030, 16'd2);
        chk("R5 outer la", la, 16'h0030);
        chk("R5 outer cnt", cnt, 2);
        do_cmd(16'h0022, 16'h0028, 16'd2);
        chk("R5 inner la", la, 16'h0028);
        pc = 16'h0028; #1;
        chk("R6 inner redir", redir, 1);
        chk("R6 inner target", redir_pc, 16'h0023);
        tick();
        chk("R6 inner cnt", cnt, 1);
        pc = 16'h0028; #1;
        chk("R7 inner last no redir", redir, 0);
        tick();
        chk("R7 outer la back", la, 16'h0030);
        chk("R7 outer cnt back", cnt, 2);
        chk("R7 outer flag", lf, 1);
        pc = 16'h0030; #1;
        chk("R6 outer redir", redir, 1);
        chk("R6 outer target", redir_pc, 16'h0021);
        tick();
        pc = 16'h0030; #1;
        chk("R7 outer last", redir, 0);
        tick();
        chk("R7 exit flag", lf, 0);
        chk("R10 no unf on exit", unf, 0);

        // Priority: R11
        do_cmd(16'h0040, 16'h0044, 16'd5);
        pc = 16'h0044; push = 1'b1; #1;
        chk("R11 push beats eol", redir, 0);
        tick();
        chk("R11 cnt untouched", cnt, 5);
        pop = 1'b1; tick();
        chk("R11 restored la", la, 16'h0044);
        chk("R11 restored cnt", cnt, 5);
        pc = 16'h0050; do_vld = 1'b1; do_end = 16'h0055; do_cnt = 16'd3;
        la_wr = 1'b1; la_wdata = 16'h0099;
        tick();
        chk("R11 do beats la write", la, 16'h0055);
        pc = 16'h0055; la_wr = 1'b1; la_wdata = 16'h0077; #1;
        chk("R11 la write beats eol", redir, 0);
        tick();
        chk("R8 la written", la, 16'h0077);
        chk("R11 cnt held", cnt, 3);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule